// File: doc/BRIEF.md
# Saturating Up/Down Wiper Position Controller

This block holds the tap position of a 64-step resistor ladder and moves it one step at a time under control of a three-wire interface: an active-low select, a step strobe and a direction line. The three wires are brought into the system clock domain through two-flop synchronizers. Each falling edge of the synchronized strobe that arrives while the synchronized select is low counts as one accepted step. The direction is sampled through the same synchronizer stages, so it lines up with the edge it qualifies.

The position register starts at midscale after reset. It moves up or down by one per accepted step and stops at either end of the range instead of wrapping. The block drives the binary code, the code for the opposite leg of the ladder (all-ones minus the code), and a one-hot tap-select vector. It also gives a one-cycle pulse for each accepted step and a flag that is high while the code sits at either end.

Top module: `wiper_stepper`

## Requirements
- R1: After synchronous reset (rst_n low at a rising clk edge) the code is 32, the opposite-leg code is 31, tap bit 32 is the only tap bit set, the step pulse is 0 and the end flag is 0.
- R2: An accepted step with dir_i = 1 raises the code by exactly one.
- R3: An accepted step with dir_i = 0 lowers the code by exactly one.
- R4: While sel_n_i is 1, falling strobe edges leave the code unchanged and produce no step pulse.
- R5: A rising edge of step_i never changes the code. Only falling edges step it.
- R6: At code 63, further up steps leave the code at 63.
- R7: At code 0, further down steps leave the code at 0.
- R8: comp_o always equals 63 minus code_o.
- R9: tap_o has exactly one bit set, and that bit is bit number code_o.
- R10: step_pulse_o is high for exactly one clk cycle for each accepted step, including steps that hit a saturated end.
- R11: at_end_o is 1 exactly when the code is 0 or 63.
- R12: The code changes on the third rising clk edge after step_i falls. After the second edge it still holds the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n_i | input | 1 | Active-low select, asynchronous |
| step_i | input | 1 | Step strobe; falling edge steps, asynchronous |
| dir_i | input | 1 | Direction: 1 up, 0 down, asynchronous |
| code_o | output | 6 | Wiper position code |
| comp_o | output | 6 | Opposite-leg code, 63 minus code |
| tap_o | output | 64 | One-hot tap select, bit k for code k |
| step_pulse_o | output | 1 | One-cycle pulse per accepted step |
| at_end_o | output | 1 | High while the code is 0 or 63 |

## Verification
The hardest case to reach is saturation. Driving the register to either rail takes dozens of correctly spaced strobe edges. At the rail, the step must still be accepted and must still pulse, while the code must stay where it is. The bench starts from midscale and walks well past 63, then well past 0. For each edge it counts pulses separately from the code. It also checks the exact synchronizer latency by sampling between the second and third clock edges after a strobe fall.

// File: rtl/wiper_pkg.sv
// Shared sizing for the wiper position controller.
// Assumes a power-of-two ladder with 2**WIPER_W taps.
package wiper_pkg;
    localparam int WIPER_W = 6;
    localparam int SYNC_BITS = 3;   // {dir, sel_n, step}
endpackage

// File: rtl/wiper_sync.sv
// Two-flop synchronizer for a bus of unrelated asynchronous bits.
// Assumes each bit is held far longer than two clk periods, so bits need no mutual coherence.
module wiper_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;

    // Two stages of resynchronization, loaded with the idle value on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q_o    <= RST_VAL;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/wiper_fall_det.sv
// Falling-edge detector on a synchronized strobe.
// Assumes the input is already in the clk domain. Its reset history is 0, so no edge can appear right after reset.
module wiper_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic fall_o
);
    logic prev_q;

    // Remember the last sampled level of the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig_i;
    end

    assign fall_o = prev_q & ~sig_i;
endmodule

// File: rtl/wiper_counter.sv
// Saturating up/down position register with midscale reset and an accept pulse.
// Assumes step_en_i is never high on two consecutive cycles.
module wiper_counter #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_en_i,
    input  logic         up_i,
    output logic [W-1:0] code_o,
    output logic         pulse_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};
    localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ONE = W'(1);

    // Step the code by one toward the requested end, stopping at the rails.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o  <= MID;
            pulse_o <= 1'b0;
        end else begin
            pulse_o <= step_en_i;
            if (step_en_i) begin
                if (up_i && code_o != TOP)        code_o <= code_o + ONE;
                else if (!up_i && code_o != '0)   code_o <= code_o - ONE;
            end
        end
    end

    // R2
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en_i && up_i && code_o != TOP) |=> code_o == $past(code_o) + ONE);
    // R3
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en_i && !up_i && code_o != '0) |=> code_o == $past(code_o) - ONE);
    // R6
    no_wrap_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en_i && up_i && code_o == TOP) |=> code_o == TOP);
    // R7
    no_wrap_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en_i && !up_i && code_o == '0) |=> code_o == '0);
    // R4
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en_i |=> $stable(code_o));
endmodule

// File: rtl/wiper_tap_dec.sv
// One-hot tap decoder: bit k is set when the code equals k.
// Assumes the code comes straight from a register, so the vector changes only when the code does.
module wiper_tap_dec #(
    parameter int W = 6,
    localparam int TAPS = 1 << W
) (
    input  logic [W-1:0]    code_i,
    output logic [TAPS-1:0] tap_o
);
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        assign tap_o[k] = (code_i == W'(k));
    end
endmodule

// File: rtl/wiper_stepper.sv
// Top of the wiper position controller: synchronizes the three-wire interface,
// qualifies falling strobe edges with select, and drives the code, the opposite-leg code, the tap vector and the status outputs.
// Assumes interface timing that holds each level for at least three clk periods.
module wiper_stepper #(
    parameter int W = wiper_pkg::WIPER_W,
    localparam int TAPS = 1 << W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_n_i,
    input  logic            step_i,
    input  logic            dir_i,
    output logic [W-1:0]    code_o,
    output logic [W-1:0]    comp_o,
    output logic [TAPS-1:0] tap_o,
    output logic            step_pulse_o,
    output logic            at_end_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [wiper_pkg::SYNC_BITS-1:0] raw_in, sync_q;
    logic fall, step_en;

    assign raw_in = {dir_i, sel_n_i, step_i};

    wiper_sync #(.W(wiper_pkg::SYNC_BITS), .RST_VAL(3'b010)) sync_i (
        .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(sync_q)
    );

    wiper_fall_det fall_i (
        .clk(clk), .rst_n(rst_n), .sig_i(sync_q[0]), .fall_o(fall)
    );

    assign step_en = fall & ~sync_q[1];

    wiper_counter #(.W(W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .step_en_i(step_en), .up_i(sync_q[2]),
        .code_o(code_o), .pulse_o(step_pulse_o)
    );

    wiper_tap_dec #(.W(W)) dec_i (.code_i(code_o), .tap_o(tap_o));

    assign comp_o   = code_o ^ TOP;
    assign at_end_o = (code_o == '0) || (code_o == TOP);

    // R8
    comp_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, code_o} + {1'b0, comp_o}) == {1'b0, TOP});
    // R9
    tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tap_o) == 1 && tap_o[code_o]);
    // R10
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_pulse_o |=> !step_pulse_o);
    // R11
    end_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        at_end_o == (tap_o[0] | tap_o[TAPS-1]));
endmodule

// File: tb/wiper_stepper_tb_top.sv
`timescale 1ns/1ps
// Directed bench for the wiper position controller: one task per scenario.
module wiper_stepper_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n_i = 1'b1;
    logic step_i = 1'b1;
    logic dir_i = 1'b1;
    logic [5:0]  code_o, comp_o;
    logic [63:0] tap_o;
    logic        step_pulse_o, at_end_o;

    int checks = 0;
    int failures = 0;
    int pulses = 0;
    int exp_code = 32;

    always #2.5 clk = ~clk;

    wiper_stepper dut_i (
        .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n_i), .step_i(step_i), .dir_i(dir_i),
        .code_o(code_o), .comp_o(comp_o), .tap_o(tap_o),
        .step_pulse_o(step_pulse_o), .at_end_o(at_end_o)
    );

    // Count pulse cycles away from the active edge.
    always @(negedge clk) if (rst_n && step_pulse_o) pulses++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Check every output against the model code (R8, R9, R11 on each call).
    task automatic check_outputs(input string req);
        check(code_o == 6'(exp_code), req, code_o, exp_code);
        check(comp_o == 6'(63 - exp_code), "R8", comp_o, 63 - exp_code);
        check(tap_o == (64'd1 << exp_code), "R9", $clog2(tap_o), exp_code);
        check(at_end_o == (exp_code == 0 || exp_code == 63), "R11", at_end_o,
              int'(exp_code == 0 || exp_code == 63));
    endtask

    task automatic one_step(input logic up);
        @(negedge clk) dir_i = up;
        repeat (3) @(negedge clk);
        step_i = 1'b0;
        repeat (4) @(negedge clk);
        step_i = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic model_step(input logic up);
        if (up && exp_code < 63) exp_code++;
        else if (!up && exp_code > 0) exp_code--;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_outputs("R1");
        check(step_pulse_o == 1'b0, "R1", step_pulse_o, 0);
        @(negedge clk) sel_n_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_inc();
        int p0 = pulses;
        for (int i = 0; i < 3; i++) begin
            one_step(1'b1); model_step(1'b1);
            check_outputs("R2");
        end
        check(pulses - p0 == 3, "R10", pulses - p0, 3);
    endtask

    task automatic t_dec();
        int p0 = pulses;
        for (int i = 0; i < 5; i++) begin
            one_step(1'b0); model_step(1'b0);
            check_outputs("R3");
        end
        check(pulses - p0 == 5, "R10", pulses - p0, 5);
    endtask

    task automatic t_deselect();
        int p0;
        @(negedge clk) sel_n_i = 1'b1;
        repeat (4) @(negedge clk);
        p0 = pulses;
        one_step(1'b1);
        one_step(1'b0);
        one_step(1'b0);
        check_outputs("R4");
        check(pulses == p0, "R4", pulses - p0, 0);
        @(negedge clk) sel_n_i = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_rise_only();
        @(negedge clk) dir_i = 1'b1;
        repeat (3) @(negedge clk);
        step_i = 1'b0;
        repeat (4) @(negedge clk);
        model_step(1'b1);
        check_outputs("R5");
        step_i = 1'b1;
        repeat (6) @(negedge clk);
        check_outputs("R5");
    endtask

    task automatic t_latency();
        int old = exp_code;
        @(negedge clk) dir_i = 1'b1;
        repeat (3) @(negedge clk);
        step_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(code_o == 6'(old), "R12", code_o, old);
        @(negedge clk);
        model_step(1'b1);
        check(code_o == 6'(exp_code), "R12", code_o, exp_code);
        check(step_pulse_o == 1'b1, "R10", step_pulse_o, 1);
        @(negedge clk);
        check(step_pulse_o == 1'b0, "R10", step_pulse_o, 0);
        step_i = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_sat_top();
        int p0 = pulses;
        for (int i = 0; i < 40; i++) begin
            one_step(1'b1); model_step(1'b1);
        end
        check(exp_code == 63, "R6", exp_code, 63);
        check_outputs("R6");
        check(pulses - p0 == 40, "R10", pulses - p0, 40);
    endtask

    task automatic t_sat_bottom();
        int p0 = pulses;
        for (int i = 0; i < 70; i++) begin
            one_step(1'b0); model_step(1'b0);
        end
        check_outputs("R7");
        check(pulses - p0 == 70, "R10", pulses - p0, 70);
        one_step(1'b1); model_step(1'b1);
        check_outputs("R2");
    endtask

    initial begin
        t_reset();
        t_inc();
        t_dec();
        t_deselect();
        t_rise_only();
        t_latency();
        t_sat_top();
        t_sat_bottom();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule